// File: doc/BRIEF.md
# Multi-Sector Erase Queue with Acceptance Window

This block gathers the sectors for one multi-sector erase. The command decoder ahead of it presents one decoded command per cycle. The first in-range sector-erase command seen while the block is idle marks that sector in a one-bit-per-sector mask and opens an acceptance window. While the window is open, further sector-erase commands mark more sectors, in any order and in any number up to the whole device. Each accepted command restarts the window. When a full window passes with no new sector, the block freezes the mask, raises a closed-window status bit and sends a one-cycle start pulse to the erase engine. The mask is then held until the engine reports completion.

While the window is open, an erase-suspend command leaves the queue and the timer untouched. Any other command empties the queue, pulses a cancel output and returns the block to idle. The window length is set in microseconds and converted to clock cycles from the clock frequency parameter. With the default 50 µs window, a 10 MHz clock gives 500 cycles and a 50 MHz clock gives 2500 cycles.

Top module: `sector_erase_queue`

## Requirements
- R1: In idle, a sector-erase command (cmd_op = 2'b01) whose sector index is below SECTORS makes erase_mask hold only bit [index]. In the next cycle window_open is 1 and window_closed is 0.
- R2: While the window is open, each in-range sector-erase command sets its own mask bit. Bits set earlier are kept, indices may come in any order, and a bit that is already set stays set with no other change.
- R3: Each accepted sector command restarts the window. erase_start goes high exactly WIN_CYCLES = (CLK_HZ/1000)*WINDOW_US/1000 cycles after the clock edge that accepted the last sector, and never earlier.
- R4: window_closed is 0 in idle and while the window is open. It is 1 from the erase_start cycle until the cycle after engine_done is sampled.
- R5: While the window is open, a command with cmd_op 2'b00 or 2'b11 clears erase_mask and returns the block to idle (window_open 0). queue_cancel pulses for one cycle and no erase_start follows.
- R6: An erase-suspend command (cmd_op = 2'b10) during the window changes neither the mask nor the time of erase_start.
- R7: Once the window has closed, sector-erase commands and all other commands are ignored, and erase_mask keeps its frozen value.
- R8: erase_start is high for exactly one cycle, with the complete mask on erase_mask. engine_done in the erase phase clears the mask and returns the block to idle.
- R9: A sector-erase command with an index at or above SECTORS is ignored in every state and does not restart the window. Commands other than sector erase are ignored in idle.
- R10: Reset clears erase_mask, erase_start, queue_cancel, window_open and window_closed, even in the middle of a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 2 | 01 sector erase, 10 erase suspend, 00/11 any other command |
| cmd_sector | input | SW | Sector index for a sector-erase command |
| engine_done | input | 1 | Erase engine has finished the queued sectors |
| erase_start | output | 1 | One-cycle start pulse to the erase engine |
| erase_mask | output | SECTORS | Queued sectors, bit i is sector i |
| window_open | output | 1 | Acceptance window is running |
| window_closed | output | 1 | Window expired and erase is in progress |
| queue_cancel | output | 1 | One-cycle pulse when a foreign command cancelled the queue |

## Verification
On every cycle, the assertions check that the timer stays within its window bound and that a mask set never coincides with a mask clear. They also check that erase_start is a lone pulse seen with window_closed, that a non-idle state always holds at least one queued sector, that the mask stays frozen through the erase phase, and that a cancel leaves an empty idle queue. The exact cycle of erase_start after the last sector, the restart by each addition, the neutrality of suspend, out-of-range indices, reset in mid-window and random multi-sector sequences are shown only by the bench scenarios against its own expected masks and cycle counts.

// File: rtl/sq_pkg.sv
`timescale 1ns/1ps
package sq_pkg;
   localparam logic [1:0] OP_SECTOR  = 2'b01;
   localparam logic [1:0] OP_SUSPEND = 2'b10;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_OPEN  = 2'd1,
      ST_ERASE = 2'd2
   } sq_state_e;
endpackage

// File: rtl/sq_window_timer.sv
`timescale 1ns/1ps
module sq_window_timer #(
   parameter int unsigned WIN_CYCLES = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic expired
);
   localparam int unsigned CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

   generate
      if (WIN_CYCLES < 1) begin : g_bad_win
         $error("sq_window_timer: WIN_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (restart)               cnt <= '0;
      else if (run && (cnt != LAST))  cnt <= cnt + 1'b1;
   end

   assign expired = run && (cnt == LAST);

   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST)
      else $error("window counter beyond its bound");
endmodule

// File: rtl/sq_sector_bits.sv
`timescale 1ns/1ps
module sq_sector_bits #(
   parameter int unsigned SECTORS = 71,
   parameter int unsigned SW      = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [SW-1:0]      set_idx,
   input  logic               clr,
   output logic [SECTORS-1:0] mask
);
   generate
      if (SECTORS < 1 || (1 << SW) < SECTORS) begin : g_bad_size
         $error("sq_sector_bits: SW too narrow for SECTORS");
      end
      for (genvar i = 0; i < SECTORS; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               mask[i] <= 1'b0;
            else if (clr)                             mask[i] <= 1'b0;
            else if (set_en && (set_idx == SW'(i)))   mask[i] <= 1'b1;
         end
      end
   endgenerate

   assert_no_set_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_en && clr))
      else $error("mask set and clear in the same cycle");
endmodule

// File: rtl/sq_queue_ctrl.sv
`timescale 1ns/1ps
module sq_queue_ctrl
   import sq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_op,
   input  logic       in_range,
   input  logic       expired,
   input  logic       engine_done,
   output sq_state_e  state,
   output logic       accept,
   output logic       clr,
   output logic       start_q,
   output logic       cancel_q
);
   logic sec_cmd, oth_cmd, cancel_now, expire_now;
   sq_state_e nxt;

   always_comb begin
      sec_cmd    = cmd_valid && (cmd_op == OP_SECTOR) && in_range;
      oth_cmd    = cmd_valid && (cmd_op != OP_SECTOR) && (cmd_op != OP_SUSPEND);
      accept     = sec_cmd && (state != ST_ERASE);
      cancel_now = (state == ST_OPEN) && oth_cmd;
      expire_now = (state == ST_OPEN) && expired && !sec_cmd && !oth_cmd;
      clr        = cancel_now || ((state == ST_ERASE) && engine_done);
      nxt        = state;
      case (state)
         ST_IDLE:  if (accept) nxt = ST_OPEN;
         ST_OPEN:  if (cancel_now) nxt = ST_IDLE;
                   else if (expire_now) nxt = ST_ERASE;
         ST_ERASE: if (engine_done) nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         start_q  <= 1'b0;
         cancel_q <= 1'b0;
      end else begin
         state    <= nxt;
         start_q  <= expire_now;
         cancel_q <= cancel_now;
      end
   end

   assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q)
      else $error("start longer than one cycle");

   assert_cancel_from_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_q |-> (state == ST_IDLE) && !start_q)
      else $error("cancel not followed by idle");
endmodule

// File: rtl/sector_erase_queue.sv
`timescale 1ns/1ps
module sector_erase_queue
   import sq_pkg::*;
#(
   parameter int unsigned CLK_HZ    = 10_000_000,
   parameter int unsigned WINDOW_US = 50,
   parameter int unsigned SECTORS   = 71,
   parameter int unsigned SW        = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [1:0]         cmd_op,
   input  logic [SW-1:0]      cmd_sector,
   input  logic               engine_done,
   output logic               erase_start,
   output logic [SECTORS-1:0] erase_mask,
   output logic               window_open,
   output logic               window_closed,
   output logic               queue_cancel
);
   localparam int unsigned WIN_CYCLES = (CLK_HZ / 1000) * WINDOW_US / 1000;
   localparam logic [SW:0] NSEC = (SW + 1)'(SECTORS);

   generate
      if (WIN_CYCLES < 1) begin : g_bad_clock
         $error("sector_erase_queue: window shorter than one clock");
      end
   endgenerate

   sq_state_e state;
   logic in_range, accept, clr, expired;

   assign in_range = ({1'b0, cmd_sector} < NSEC);

   sq_queue_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .in_range(in_range), .expired(expired), .engine_done(engine_done),
      .state(state), .accept(accept), .clr(clr),
      .start_q(erase_start), .cancel_q(queue_cancel)
   );

   sq_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(accept),
      .run(state == ST_OPEN), .expired(expired)
   );

   sq_sector_bits #(.SECTORS(SECTORS), .SW(SW)) u_bits (
      .clk(clk), .rst_n(rst_n), .set_en(accept), .set_idx(cmd_sector),
      .clr(clr), .mask(erase_mask)
   );

   assign window_open   = (state == ST_OPEN);
   assign window_closed = (state == ST_ERASE);

   assert_queue_nonempty_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |-> (|erase_mask))
      else $error("active state with empty queue");

   assert_mask_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_ERASE) && ($past(state) == ST_ERASE)) |-> $stable(erase_mask))
      else $error("mask changed during erase");

   assert_cancel_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
      queue_cancel |-> (erase_mask == '0))
      else $error("cancel left sectors queued");

   assert_start_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |-> window_closed && !window_open)
      else $error("start without closed window");
endmodule

// File: tb/sector_erase_queue_test.sv
`timescale 1ns/1ps
module sector_erase_queue_test;
   localparam int unsigned CLK_HZ  = 50_000_000;
   localparam int unsigned WIN_US  = 4;
   localparam int unsigned SECTORS = 71;
   localparam int unsigned SW      = 7;
   localparam int W = int'((CLK_HZ / 1000) * WIN_US / 1000);

   logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, engine_done = 1'b0;
   logic [1:0] cmd_op = 2'b00;
   logic [SW-1:0] cmd_sector = '0;
   logic erase_start, window_open, window_closed, queue_cancel;
   logic [SECTORS-1:0] erase_mask;

   int checks = 0, fails = 0, starts = 0;
   bit done = 1'b0;

   sector_erase_queue #(.CLK_HZ(CLK_HZ), .WINDOW_US(WIN_US), .SECTORS(SECTORS), .SW(SW)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_sector(cmd_sector), .engine_done(engine_done), .erase_start(erase_start),
      .erase_mask(erase_mask), .window_open(window_open), .window_closed(window_closed),
      .queue_cancel(queue_cancel)
   );

   always #10 clk = ~clk;
   always @(posedge clk) if (erase_start) starts++;

   function automatic logic [SECTORS-1:0] bit_of(int s);
      logic [SECTORS-1:0] m = '0;
      m[s] = 1'b1;
      return m;
   endfunction

   task automatic chk(string rq, string what, longint act, longint exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic chk_mask(string rq, logic [SECTORS-1:0] exp);
      checks++;
      if (erase_mask !== exp) begin
         fails++;
         $display("FAIL %s mask: got %h expected %h", rq, erase_mask, exp);
      end
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic issue(logic [1:0] op, int sec);
      cmd_valid  = 1'b1;
      cmd_op     = op;
      cmd_sector = SW'(sec);
      @(negedge clk);
      cmd_valid  = 1'b0;
      cmd_op     = 2'b00;
   endtask

   // elapsed: cycles already gone since the edge that accepted the last sector
   task automatic expect_start(string rq, int elapsed, logic [SECTORS-1:0] exp);
      wait_n(W - 1 - elapsed);
      chk(rq, "start before window end", erase_start, 0);
      chk(rq, "open before window end", window_open, 1);
      wait_n(1);
      chk(rq, "start at window end", erase_start, 1);
      chk("R4", "closed at start", window_closed, 1);
      chk_mask("R8", exp);
      wait_n(1);
      chk("R8", "start one cycle", erase_start, 0);
   endtask

   task automatic finish_erase();
      engine_done = 1'b1;
      @(negedge clk);
      engine_done = 1'b0;
      chk_mask("R8", '0);
      chk("R4", "closed after done", window_closed, 0);
      chk("R8", "idle after done", window_open, 0);
   endtask

   initial begin
      logic [SECTORS-1:0] exp;
      int s0;
      void'($urandom(32'd2024));
      wait_n(3);
      chk("R10", "start in reset", erase_start, 0);
      chk_mask("R10", '0);
      rst_n = 1'b1;
      wait_n(1);
      chk("R10", "open after reset", window_open, 0);
      chk("R10", "closed after reset", window_closed, 0);
      chk("R10", "cancel after reset", queue_cancel, 0);

      // R9: idle ignores other commands and out-of-range sectors
      issue(2'b11, 3);
      chk_mask("R9", '0);
      issue(2'b01, 75);
      chk_mask("R9", '0);
      chk("R9", "out of range opens nothing", window_open, 0);

      // R1, R2, R3, R7, R8
      issue(2'b01, 5);
      chk_mask("R1", bit_of(5));
      chk("R1", "window open", window_open, 1);
      chk("R1", "window not closed", window_closed, 0);
      issue(2'b01, 70);
      issue(2'b01, 0);
      exp = bit_of(5) | bit_of(70) | bit_of(0);
      chk_mask("R2", exp);
      issue(2'b01, 5);
      chk_mask("R2", exp);
      expect_start("R3", 0, exp);
      issue(2'b01, 9);
      chk_mask("R7", exp);
      issue(2'b00, 0);
      chk_mask("R7", exp);
      chk("R7", "still closed", window_closed, 1);
      finish_erase();

      // R3: a later addition restarts the window
      issue(2'b01, 3);
      wait_n(W - 5);
      issue(2'b01, 4);
      expect_start("R3", 0, bit_of(3) | bit_of(4));
      finish_erase();

      // R6: suspend neither adds nor restarts
      issue(2'b01, 2);
      wait_n(10);
      issue(2'b10, 40);
      chk_mask("R6", bit_of(2));
      expect_start("R6", 11, bit_of(2));
      finish_erase();

      // R9: out-of-range during the window does not restart it
      issue(2'b01, 7);
      wait_n(20);
      issue(2'b01, 127);
      expect_start("R9", 21, bit_of(7));
      finish_erase();

      // R5: foreign command cancels
      s0 = starts;
      issue(2'b01, 1);
      wait_n(20);
      issue(2'b11, 1);
      chk("R5", "cancel pulse", queue_cancel, 1);
      chk_mask("R5", '0);
      chk("R5", "back to idle", window_open, 0);
      wait_n(1);
      chk("R5", "cancel one cycle", queue_cancel, 0);
      issue(2'b01, 8);
      wait_n(4);
      issue(2'b00, 0);
      chk_mask("R5", '0);
      wait_n(W + 5);
      chk("R5", "no start after cancel", starts - s0, 0);

      // R2: every sector, descending
      exp = '0;
      for (int k = SECTORS - 1; k >= 0; k--) begin
         issue(2'b01, k);
         exp[k] = 1'b1;
      end
      chk_mask("R2", exp);
      expect_start("R2", 0, exp);
      finish_erase();

      // R10: reset in the middle of a window
      issue(2'b01, 33);
      wait_n(5);
      rst_n = 1'b0;
      wait_n(1);
      chk_mask("R10", '0);
      chk("R10", "open cleared", window_open, 0);
      rst_n = 1'b1;
      wait_n(W + 2);
      chk("R10", "no start after reset", window_closed, 0);

      // R2, R3: random sequences
      for (int r = 0; r < 8; r++) begin
         int n;
         exp = '0;
         n = 1 + int'($urandom % 10);
         for (int k = 0; k < n; k++) begin
            int s;
            if (k > 0) wait_n(int'($urandom % (W / 2)));
            s = int'($urandom % SECTORS);
            issue(2'b01, s);
            exp[s] = 1'b1;
         end
         chk_mask("R2", exp);
         expect_start("R3", 0, exp);
         wait_n(int'($urandom % 20));
         chk_mask("R7", exp);
         finish_erase();
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule